// File: doc/BRIEF.md
# SDRAM Command One-Shot Gate

This block sits on the command path between a slow controller and an SDRAM that runs on a clock about ten times faster. The controller holds its chip-select, row-strobe, column-strobe, write-enable and address lines steady for a whole slow period. Without this block, the memory would see that command on every fast cycle of the period. For reads and writes to a fixed address, seeing the command many times does no harm. For activate, precharge and mode-register load, it does.

The block lives in the fast clock domain. It registers the held lines through a short flop chain and then classifies the word. Repeatable words are forwarded on every cycle. A non-repeatable word gets chip-select low for a single fast cycle. After that, chip-select stays high until the controller presents a different word.

After the last cycle of a READ, the block holds off any different command for the CAS latency, because the read data returns on shared pins. A command held off in this way is issued once that window ends. The block never creates a command of its own, so it inserts no refresh.

Top module: `sdram_cmd_oneshot`

## Requirements
- R1: A synchronous active-high reset drives mem_cs_n, mem_ras_n, mem_cas_n and mem_we_n high and mem_addr to zero on the next edge, and it clears all internal history.
- R2: With the default two-flop input chain, an input word reaches the outputs on the third rising edge after it is driven. This applies to every output, including the cycles after reset is released.
- R3: Command codes are read as {cs_n, ras_n, cas_n, we_n}. ACTIVATE is 0011, PRECHARGE is 0010 and LOAD MODE is 0000, and these three are single-shot. READ is 0101, WRITE is 0100 and NOP is 0111, and these and every other code with cs_n low are repeatable.
- R4: A repeatable command with cs_n low appears unchanged on the outputs for every cycle the controller holds it.
- R5: A single-shot command gives exactly one output cycle with mem_cs_n low, carrying the full word. After that, the outputs show cs_n, ras_n, cas_n and we_n all high, with the held address, until the input word changes.
- R6: A change in any bit of the input word starts a new command, and that includes a change of address alone. A single-shot word that follows another single-shot word with a different address therefore produces a second pulse.
- R7: An input word with cs_n high passes through unchanged.
- R8: After the last output cycle of a READ, for CAS_LAT cycles the output is either that same READ word or deselect (1111 with the input address). A held command that differs from the READ appears on the first cycle after the window, and a single-shot command is still issued exactly once.
- R9: Whenever mem_cs_n is low, the output word equals the input word from three edges earlier. The block adds no command of its own, refresh included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | SDRAM-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| ctl_cs_n | input | 1 | Controller chip-select, active low |
| ctl_ras_n | input | 1 | Controller row strobe, active low |
| ctl_cas_n | input | 1 | Controller column strobe, active low |
| ctl_we_n | input | 1 | Controller write enable, active low |
| ctl_addr | input | ADDR_W | Controller address |
| mem_cs_n | output | 1 | Gated chip-select to the SDRAM |
| mem_ras_n | output | 1 | Row strobe to the SDRAM |
| mem_cas_n | output | 1 | Column strobe to the SDRAM |
| mem_we_n | output | 1 | Write enable to the SDRAM |
| mem_addr | output | ADDR_W | Address to the SDRAM |

## Verification
Every input word takes three rising edges to reach the outputs. A single-shot pulse is due on exactly the third edge after the word changes. A command held behind a READ is due CAS_LAT cycles after the last READ output cycle, which is the sixteenth edge when a ten-cycle READ is followed directly by another command.

The bench drives inputs on the falling edge and samples the outputs on the falling edge before each new drive. It keeps a table of expected output words indexed by drive cycle plus three, and it compares every cycle of each scenario against that table, including the deselect cycles with their address.

After a reset is released, the first two samples must still show idle and the held command must appear on the third.

// File: rtl/sdram_cmd_oneshot_pkg.sv
package sdram_cmd_oneshot_pkg;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } cmd_lines_t;

    localparam cmd_lines_t CMD_DESELECT = '{cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};

    // Activate, precharge and mode load: must reach the device only once.
    function automatic logic is_single_shot(cmd_lines_t c);
        logic hit;
        case ({c.ras_n, c.cas_n, c.we_n})
            3'b011, 3'b010, 3'b000: hit = 1'b1;
            default:                hit = 1'b0;
        endcase
        return hit && !c.cs_n;
    endfunction

    function automatic logic is_read(cmd_lines_t c);
        return !c.cs_n && ({c.ras_n, c.cas_n, c.we_n} == 3'b101);
    endfunction

endpackage

// File: rtl/cmd_sync_chain.sv
module cmd_sync_chain #(
    parameter int          WIDTH     = 17,
    parameter int          STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    assign stage_d[0] = rst ? RESET_VAL : d_i;

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        assign stage_d[s] = rst ? RESET_VAL : stage_q[s-1];
    end

    always_ff @(posedge clk) begin
        for (int s = 0; s < STAGES; s++) begin
            stage_q[s] <= stage_d[s];
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/cmd_read_guard.sv
module cmd_read_guard #(
    parameter int CAS_LAT = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic read_next_i,
    output logic guard_o
);
    localparam int CW = $clog2(CAS_LAT + 1);

    typedef struct packed {
        logic [CW-1:0] left;
    } guard_state_t;

    guard_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.left = '0;
        end else if (read_next_i) begin
            st_d.left = CW'(CAS_LAT);
        end else if (st_q.left != '0) begin
            st_d.left = st_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign guard_o = (st_q.left != '0);
endmodule

// File: rtl/cmd_oneshot_ctrl.sv
module cmd_oneshot_ctrl
    import sdram_cmd_oneshot_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  cmd_lines_t        w_cmd_i,
    input  logic [ADDR_W-1:0] w_addr_i,
    input  logic              guard_i,
    output logic              read_next_o,
    output cmd_lines_t        o_cmd_o,
    output logic [ADDR_W-1:0] o_addr_o
);
    typedef struct packed {
        cmd_lines_t        cmd;
        logic [ADDR_W-1:0] addr;
    } word_t;

    typedef struct packed {
        word_t prev;
        logic  issued;
        word_t out;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;
    word_t       w_now;
    word_t       w_desel;
    logic        new_word;
    logic        blocked;
    logic        held_issued;
    logic        fire;

    always_comb begin
        w_now       = '{cmd: w_cmd_i, addr: w_addr_i};
        w_desel     = '{cmd: CMD_DESELECT, addr: w_addr_i};
        new_word    = (w_now != st_q.prev);
        blocked     = guard_i && (w_now != st_q.out);
        held_issued = new_word ? 1'b0 : st_q.issued;
        fire        = 1'b0;

        st_d      = st_q;
        st_d.prev = w_now;

        if (blocked) begin
            st_d.out = w_desel;
        end else if (is_single_shot(w_now.cmd)) begin
            fire     = !held_issued;
            st_d.out = fire ? w_now : w_desel;
        end else begin
            st_d.out = w_now;
        end
        st_d.issued = held_issued | fire;

        if (rst) begin
            st_d.prev   = '{cmd: CMD_DESELECT, addr: '0};
            st_d.out    = '{cmd: CMD_DESELECT, addr: '0};
            st_d.issued = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign read_next_o = is_read(st_d.out.cmd);
    assign o_cmd_o     = st_q.out.cmd;
    assign o_addr_o    = st_q.out.addr;
endmodule

// File: rtl/sdram_cmd_oneshot.sv
module sdram_cmd_oneshot
    import sdram_cmd_oneshot_pkg::*;
#(
    parameter int ADDR_W      = 13,
    parameter int SYNC_STAGES = 2,
    parameter int CAS_LAT     = 3
) (
    input  logic              clk_fast,
    input  logic              rst,
    input  logic              ctl_cs_n,
    input  logic              ctl_ras_n,
    input  logic              ctl_cas_n,
    input  logic              ctl_we_n,
    input  logic [ADDR_W-1:0] ctl_addr,
    output logic              mem_cs_n,
    output logic              mem_ras_n,
    output logic              mem_cas_n,
    output logic              mem_we_n,
    output logic [ADDR_W-1:0] mem_addr
);
    localparam int WORD_W = 4 + ADDR_W;
    localparam logic [WORD_W-1:0] IDLE_WORD = {4'b1111, {ADDR_W{1'b0}}};

    logic [WORD_W-1:0] in_word;
    logic [WORD_W-1:0] sync_word;
    cmd_lines_t        w_cmd;
    logic [ADDR_W-1:0] w_addr;
    cmd_lines_t        o_cmd;
    logic              guard;
    logic              read_next;

    assign in_word = {ctl_cs_n, ctl_ras_n, ctl_cas_n, ctl_we_n, ctl_addr};

    cmd_sync_chain #(
        .WIDTH    (WORD_W),
        .STAGES   (SYNC_STAGES),
        .RESET_VAL(IDLE_WORD)
    ) u_sync (
        .clk(clk_fast),
        .rst(rst),
        .d_i(in_word),
        .q_o(sync_word)
    );

    assign w_cmd  = cmd_lines_t'(sync_word[WORD_W-1 -: 4]);
    assign w_addr = sync_word[ADDR_W-1:0];

    cmd_read_guard #(
        .CAS_LAT(CAS_LAT)
    ) u_guard (
        .clk        (clk_fast),
        .rst        (rst),
        .read_next_i(read_next),
        .guard_o    (guard)
    );

    cmd_oneshot_ctrl #(
        .ADDR_W(ADDR_W)
    ) u_ctrl (
        .clk        (clk_fast),
        .rst        (rst),
        .w_cmd_i    (w_cmd),
        .w_addr_i   (w_addr),
        .guard_i    (guard),
        .read_next_o(read_next),
        .o_cmd_o    (o_cmd),
        .o_addr_o   (mem_addr)
    );

    assign mem_cs_n  = o_cmd.cs_n;
    assign mem_ras_n = o_cmd.ras_n;
    assign mem_cas_n = o_cmd.cas_n;
    assign mem_we_n  = o_cmd.we_n;
endmodule

// File: rtl/sdram_cmd_oneshot_chk.sv
module sdram_cmd_oneshot_chk #(
    parameter int ADDR_W      = 13,
    parameter int SYNC_STAGES = 2,
    parameter int CAS_LAT     = 3
) (
    input logic              clk_fast,
    input logic              rst,
    input logic              ctl_cs_n,
    input logic              ctl_ras_n,
    input logic              ctl_cas_n,
    input logic              ctl_we_n,
    input logic [ADDR_W-1:0] ctl_addr,
    input logic              mem_cs_n,
    input logic              mem_ras_n,
    input logic              mem_cas_n,
    input logic              mem_we_n,
    input logic [ADDR_W-1:0] mem_addr
);
    localparam int WORD_W = 4 + ADDR_W;
    localparam int CW     = $clog2(CAS_LAT + 1);

    logic [WORD_W-1:0] in_w;
    logic [WORD_W-1:0] out_w;
    logic              out_single;
    logic              out_read;
    logic [2:0]        since_rst;
    logic [CW-1:0]     rd_left;
    logic [WORD_W-1:0] rd_word;

    assign in_w       = {ctl_cs_n, ctl_ras_n, ctl_cas_n, ctl_we_n, ctl_addr};
    assign out_w      = {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n, mem_addr};
    assign out_single = !mem_cs_n && ({mem_ras_n, mem_cas_n, mem_we_n} inside {3'b011, 3'b010, 3'b000});
    assign out_read   = !mem_cs_n && ({mem_ras_n, mem_cas_n, mem_we_n} == 3'b101);

    always_ff @(posedge clk_fast) begin
        if (rst) begin
            since_rst <= '0;
            rd_left   <= '0;
            rd_word   <= '0;
        end else begin
            if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
            if (out_read) begin
                rd_left <= CW'(CAS_LAT);
                rd_word <= out_w;
            end else if (rd_left != '0) begin
                rd_left <= rd_left - 1'b1;
            end
        end
    end

    // R1
    a_r1_reset_idle: assert property (@(posedge clk_fast)
        rst |=> (mem_cs_n && mem_ras_n && mem_cas_n && mem_we_n && mem_addr == '0));

    // R5
    a_r5_single_pulse: assert property (@(posedge clk_fast) disable iff (rst)
        out_single |=> (mem_cs_n || out_w != $past(out_w)));

    // R8
    a_r8_read_window: assert property (@(posedge clk_fast) disable iff (rst)
        (rd_left != '0 && out_w != rd_word) |-> (mem_cs_n && mem_ras_n && mem_cas_n && mem_we_n));

    if (SYNC_STAGES == 2) begin : g_lat3
        // R9
        a_r9_no_own_command: assert property (@(posedge clk_fast) disable iff (rst)
            (since_rst >= 3'd3 && !mem_cs_n) |-> (out_w == $past(in_w, 3)));
        // R7
        a_r7_desel_origin: assert property (@(posedge clk_fast) disable iff (rst)
            (since_rst >= 3'd3 && mem_cs_n) |->
                (out_w == $past(in_w, 3) || (mem_ras_n && mem_cas_n && mem_we_n)));
    end
endmodule

bind sdram_cmd_oneshot sdram_cmd_oneshot_chk #(
    .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES), .CAS_LAT(CAS_LAT)
) u_chk (
    .clk_fast (clk_fast),
    .rst      (rst),
    .ctl_cs_n (ctl_cs_n),
    .ctl_ras_n(ctl_ras_n),
    .ctl_cas_n(ctl_cas_n),
    .ctl_we_n (ctl_we_n),
    .ctl_addr (ctl_addr),
    .mem_cs_n (mem_cs_n),
    .mem_ras_n(mem_ras_n),
    .mem_cas_n(mem_cas_n),
    .mem_we_n (mem_we_n),
    .mem_addr (mem_addr)
);

// File: tb/test_sdram_cmd_oneshot.sv
module test_sdram_cmd_oneshot;
    localparam int AW   = 8;
    localparam int NSEQ = 64;
    typedef logic [AW+3:0] word_t;

    localparam logic [3:0] C_ACT = 4'b0011;
    localparam logic [3:0] C_PRE = 4'b0010;
    localparam logic [3:0] C_LMR = 4'b0000;
    localparam logic [3:0] C_RD  = 4'b0101;
    localparam logic [3:0] C_WR  = 4'b0100;
    localparam word_t IDLE = {4'b1111, {AW{1'b0}}};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ctl_cs_n, ctl_ras_n, ctl_cas_n, ctl_we_n;
    logic [AW-1:0] ctl_addr;
    logic mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n;
    logic [AW-1:0] mem_addr;

    always #5 clk = ~clk;

    sdram_cmd_oneshot #(.ADDR_W(AW), .SYNC_STAGES(2), .CAS_LAT(3)) i_sdram_cmd_oneshot (
        .clk_fast(clk), .rst(rst),
        .ctl_cs_n(ctl_cs_n), .ctl_ras_n(ctl_ras_n), .ctl_cas_n(ctl_cas_n),
        .ctl_we_n(ctl_we_n), .ctl_addr(ctl_addr),
        .mem_cs_n(mem_cs_n), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n),
        .mem_we_n(mem_we_n), .mem_addr(mem_addr)
    );

    int checks = 0;
    int fails  = 0;
    word_t drv   [NSEQ];
    word_t exp_w [NSEQ];

    function automatic word_t mk(logic [3:0] c, logic [AW-1:0] a);
        return {c, a};
    endfunction

    function automatic word_t desel(word_t w);
        return {4'b1111, w[AW-1:0]};
    endfunction

    function automatic word_t outw();
        return {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n, mem_addr};
    endfunction

    task automatic drive(word_t w);
        {ctl_cs_n, ctl_ras_n, ctl_cas_n, ctl_we_n, ctl_addr} = w;
    endtask

    task automatic check(string tag, int idx, word_t act, word_t ex);
        checks++;
        if (act !== ex) begin
            fails++;
            $display("FAIL %s cycle %0d: actual %h expected %h", tag, idx, act, ex);
        end
    endtask

    task automatic clear_seq();
        for (int i = 0; i < NSEQ; i++) begin
            drv[i]   = IDLE;
            exp_w[i] = IDLE;
        end
    endtask

    task automatic put(int s, int n, word_t w);
        for (int i = 0; i < n; i++) drv[s+i] = w;
    endtask

    task automatic want(int s, int n, word_t w);
        for (int i = 0; i < n; i++) exp_w[s+i] = w;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk) drive(IDLE);
    endtask

    // Sample at index i shows the word driven at index i-3.
    task automatic play(int n, string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(tag, i, outw(), exp_w[i]);
            drive(drv[i]);
        end
        idle(8);
    endtask

    initial begin
        #2_000_000;
        fails++;
        checks++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        drive(IDLE);
        repeat (3) @(negedge clk);
        check("R1 reset state", 0, outw(), IDLE);
        rst = 1'b0;
        idle(8);

        // R3 R4 R5 R7 R9: sweep every code, held for ten cycles
        for (int c = 0; c < 16; c++) begin
            logic [3:0] code = 4'(c);
            word_t w = mk(code, AW'(c * 11 + 1));
            logic single = !code[3] && (code[2:0] inside {3'b011, 3'b010, 3'b000});
            clear_seq();
            put(0, 10, w);
            if (single) begin
                want(3, 1, w);
                want(4, 9, desel(w));
            end else begin
                want(3, 10, w);
            end
            play(20, single ? "R3/R5/R9 sweep" : (code[3] ? "R7 sweep" : "R3/R4/R9 sweep"));
        end

        // R6: activate to a new address fires again
        clear_seq();
        put(0, 10, mk(C_ACT, 8'h21));
        put(10, 10, mk(C_ACT, 8'h22));
        want(3, 1, mk(C_ACT, 8'h21));
        want(4, 9, desel(mk(C_ACT, 8'h21)));
        want(13, 1, mk(C_ACT, 8'h22));
        want(14, 9, desel(mk(C_ACT, 8'h22)));
        play(30, "R6 addr change");

        // R5: long mode-load hold pulses once
        clear_seq();
        put(0, 30, mk(C_LMR, 8'h33));
        want(3, 1, mk(C_LMR, 8'h33));
        want(4, 29, desel(mk(C_LMR, 8'h33)));
        play(40, "R5 long hold");

        // R8: read then precharge
        clear_seq();
        put(0, 10, mk(C_RD, 8'h40));
        put(10, 10, mk(C_PRE, 8'h41));
        want(3, 10, mk(C_RD, 8'h40));
        want(13, 3, desel(mk(C_PRE, 8'h41)));
        want(16, 1, mk(C_PRE, 8'h41));
        want(17, 6, desel(mk(C_PRE, 8'h41)));
        play(30, "R8 read->pre");

        // R8: read then read to another column
        clear_seq();
        put(0, 10, mk(C_RD, 8'h50));
        put(10, 10, mk(C_RD, 8'h51));
        want(3, 10, mk(C_RD, 8'h50));
        want(13, 3, desel(mk(C_RD, 8'h51)));
        want(16, 7, mk(C_RD, 8'h51));
        play(30, "R8 read->read");

        // R8: read then write
        clear_seq();
        put(0, 10, mk(C_RD, 8'h60));
        put(10, 10, mk(C_WR, 8'h61));
        want(3, 10, mk(C_RD, 8'h60));
        want(13, 3, desel(mk(C_WR, 8'h61)));
        want(16, 7, mk(C_WR, 8'h61));
        play(30, "R8 read->write");

        // R4 R5: write then precharge needs no window
        clear_seq();
        put(0, 10, mk(C_WR, 8'h70));
        put(10, 10, mk(C_PRE, 8'h71));
        want(3, 10, mk(C_WR, 8'h70));
        want(13, 1, mk(C_PRE, 8'h71));
        want(14, 9, desel(mk(C_PRE, 8'h71)));
        play(30, "R4/R5 write->pre");

        // R1 R2: reset in the middle of a held write, then resume
        @(negedge clk) drive(mk(C_WR, 8'h7e));
        repeat (5) @(negedge clk);
        check("R4 before reset", 0, outw(), mk(C_WR, 8'h7e));
        rst = 1'b1;
        @(negedge clk);
        check("R1 mid reset", 1, outw(), IDLE);
        rst = 1'b0;
        @(negedge clk);
        check("R2 resume edge1", 2, outw(), IDLE);
        @(negedge clk);
        check("R2 resume edge2", 3, outw(), IDLE);
        @(negedge clk);
        check("R2 resume edge3", 4, outw(), mk(C_WR, 8'h7e));
        idle(8);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule